// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory instruction into a stream of per-beat memory requests. After a start command it walks the elements from the resume point up to the vector length. For each active element it issues one request per segment field. Each request carries a byte address, a byte size, the register that the field targets and the element number. The memory system and the register file sit outside the block. The instruction is assumed to be legal when it arrives.

Three address forms are supported. In the contiguous form, the fields of all elements are packed back to back. In the strided form, each element starts at a signed byte distance from the previous one. In the indexed form, each element adds an offset taken from an index register to the base. The block presents the current element number on `elem_sel`. The surrounding logic answers in the same cycle with that element's mask bit and its raw index value. The block holds its progress on `vstart_out` so that an interrupted instruction can resume, and it pulses `done` once the walk is over.

Width codes are the log2 of the byte count: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Mode codes are 0 = contiguous, 1 = strided, 2 = indexed, and 3 behaves like 0. All configuration inputs are captured when a start is accepted.

Top module: `vmem_addr_seq`

## Requirements
- R1: After reset, `req_valid` and `done` are 0 and `vstart_out` is 0.
- R2: Beats come out with the element number in `req_elem`. The element runs from `vstart_in` up to `vl_in`-1 in the outer loop. The field runs from 0 to `nf_m1_in` in the inner loop. No beat is repeated and none is left out.
- R3: With `mask_en_in`=1, an element whose `mask_bit` is 0 produces no beats. With `mask_en_in`=0, `mask_bit` has no effect.
- R4: In mode 0 (and mode 3) the address is base + ((i*(nf_m1_in+1) + f) << `eew_in`) and `req_size` = `eew_in`.
- R5: In mode 1 the address is base + i*stride + (f << `eew_in`), with the stride read as two's complement and the sum taken modulo 2^ADDR_W. `req_size` = `eew_in`.
- R6: In mode 2 the address is base + X + (f << `sew_in`), with `req_size` = `sew_in`. X is `idx_raw` zero-extended from its low 8 << `eew_in` bits.
- R7: `req_reg` = (`vd_in` + (f << g)) mod 32. Here g is `emul_lg_in` in modes 0, 1 and 3, and `lmul_lg_in` in mode 2.
- R8: While `req_valid`=1 and `req_ready`=0, the beat is held. `req_valid` stays 1 and every request field is unchanged in the next cycle.
- R9: While an element is being walked, `vstart_out` equals that element's number. It reads 0 once the instruction has finished.
- R10: `done` is a single-cycle pulse with `req_valid`=0. It comes in the cycle after the last beat is accepted or the last element is skipped. It comes in the cycle after start when `vstart_in` >= `vl_in`.
- R11: A start raised while an instruction is in progress, or while `done` is high, is ignored. The input values offered with it are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| mode_in | input | 2 | Address form: 0 contiguous, 1 strided, 2 indexed |
| base_in | input | ADDR_W | Base byte address |
| stride_in | input | ADDR_W | Signed byte stride for the strided form |
| nf_m1_in | input | 3 | Number of segment fields minus one |
| eew_in | input | 2 | Data width code (modes 0/1) or index width code (mode 2) |
| sew_in | input | 2 | Data width code for the indexed form |
| emul_lg_in | input | 2 | log2 register group size for modes 0/1 (already clamped to >= 1 register) |
| lmul_lg_in | input | 2 | log2 register group size for mode 2 (already clamped) |
| vd_in | input | 5 | First data register |
| mask_en_in | input | 1 | Skip elements whose mask bit is 0 |
| vl_in | input | VL_W | Vector length |
| vstart_in | input | VL_W | First element to process |
| elem_sel | output | VL_W | Element whose mask bit and index value are requested |
| mask_bit | input | 1 | Mask bit of element `elem_sel` |
| idx_raw | input | IDX_W | Raw index register contents for element `elem_sel` |
| req_valid | output | 1 | A request beat is offered |
| req_ready | input | 1 | The memory side accepts the beat |
| req_addr | output | ADDR_W | Byte address of the beat |
| req_size | output | 2 | Byte size code of the beat |
| req_reg | output | 5 | Register that the beat's field targets |
| req_elem | output | VL_W | Element number of the beat |
| vstart_out | output | VL_W | Current progress (element being walked) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that `mask_bit` and `idx_raw` are pure same-cycle functions of `elem_sel`, so a held beat's fields can be required to be stable. They also assume that start is a plain level, filtered by the block itself. The stimulus answers both lookups from fixed tables addressed by `elem_sel`. It changes `req_ready`, `start` and the configuration only at falling clock edges. It keeps `vl_in` within the table depth, and it tries each mode, backpressure, masking, register wrap and an early start, all against a model written from the requirements.

// File: rtl/vmem_seq_pkg.sv
// Shared types and constants for the vector memory address sequencer.
// Assumes width codes are log2 of the byte count (0..3).
package vmem_seq_pkg;
    localparam int NF_W  = 3;  // segment field counter width (up to 8 fields)
    localparam int REG_W = 5;  // register number width (32 registers)

    typedef enum logic [1:0] {
        VM_UNIT   = 2'd0,
        VM_STRIDE = 2'd1,
        VM_INDEX  = 2'd2,
        VM_RSVD   = 2'd3
    } vmode_e;

    typedef struct packed {
        vmode_e            mode;
        logic [NF_W-1:0]   nf_m1;
        logic [1:0]        eew;
        logic [1:0]        sew;
        logic [1:0]        emul_lg;
        logic [1:0]        lmul_lg;
        logic [REG_W-1:0]  vd;
        logic              mask_en;
    } vcfg_t;
endpackage

// File: rtl/vmem_seq_ctrl.sv
// Element/field walker. Steps through elements from a resume point up to
// the vector length and fields within each element. It skips masked-off
// elements and waits on backpressure. It assumes the latched length, field
// count and mask enable are stable from the cycle after the capture pulse.
module vmem_seq_ctrl
    import vmem_seq_pkg::*;
#(
    parameter int VL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VL_W-1:0]  vstart_in,
    input  logic [VL_W-1:0]  vl_q,
    input  logic [NF_W-1:0]  nf_m1_q,
    input  logic             mask_en_q,
    input  logic             mask_bit,
    input  logic             req_ready,
    output logic             cap,
    output logic [VL_W-1:0]  elem,
    output logic [NF_W-1:0]  fld,
    output logic             req_valid,
    output logic             done,
    output logic [VL_W-1:0]  vstart_out
);
    logic            run_q;
    logic [VL_W-1:0] elem_q;
    logic [NF_W-1:0] fld_q;
    logic            fin, active, skip, last_fld;

    // Decode the walk status of the current cycle
    always_comb begin
        cap       = !run_q && start;
        fin       = run_q && (elem_q >= vl_q);
        active    = run_q && !fin;
        skip      = active && mask_en_q && !mask_bit;
        req_valid = active && !skip;
        last_fld  = (fld_q == nf_m1_q);
    end

    // Advance the element and field counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            elem_q <= '0;
            fld_q  <= '0;
        end else if (cap) begin
            run_q  <= 1'b1;
            elem_q <= vstart_in;
            fld_q  <= '0;
        end else if (fin) begin
            run_q  <= 1'b0;
            fld_q  <= '0;
        end else if (skip) begin
            elem_q <= elem_q + VL_W'(1);
            fld_q  <= '0;
        end else if (req_valid && req_ready) begin
            if (last_fld) begin
                elem_q <= elem_q + VL_W'(1);
                fld_q  <= '0;
            end else begin
                fld_q  <= fld_q + NF_W'(1);
            end
        end
    end

    // Expose progress and the completion pulse
    always_comb begin
        elem       = elem_q;
        fld        = fld_q;
        done       = fin;
        vstart_out = active ? elem_q : '0;
    end
endmodule

// File: rtl/vmem_idx_ext.sv
// Index zero-extender. Keeps the low 8/16/32/64 bits of the raw index
// value, as chosen by the width code, and widens the result to the
// address width. It assumes the width code is 0..3.
module vmem_idx_ext #(
    parameter int IDX_W  = 64,
    parameter int ADDR_W = 64
) (
    input  logic [IDX_W-1:0]  raw,
    input  logic [1:0]        wsel,
    output logic [ADDR_W-1:0] off
);
    logic [ADDR_W-1:0] cand [4];

    for (genvar k = 0; k < 4; k++) begin : g_w
        localparam int EW = 8 << k;
        if (EW < IDX_W) begin : g_cut
            assign cand[k] = ADDR_W'(raw[EW-1:0]);
        end else begin : g_full
            assign cand[k] = ADDR_W'(raw);
        end
    end

    // Pick the candidate for the selected index width
    always_comb off = cand[wsel];
endmodule

// File: rtl/vmem_addr_gen.sv
// Address and size generator for one beat. It combines the base, the mode
// specific element offset and the field offset. It assumes the element and
// field come from the walker and the index offset is already zero-extended.
// Strided products are taken modulo 2^ADDR_W, which equals signed wrap.
module vmem_addr_gen
    import vmem_seq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int VL_W   = 8
) (
    input  vmode_e            mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VL_W-1:0]   elem,
    input  logic [NF_W-1:0]   fld,
    input  logic [NF_W-1:0]   nf_m1,
    input  logic [1:0]        eew,
    input  logic [1:0]        sew,
    input  logic [ADDR_W-1:0] idx_off,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        size
);
    logic [ADDR_W-1:0] elem_x, nf_cnt, seq, fld_step;

    // Form the byte address and size for the current beat
    always_comb begin
        elem_x   = ADDR_W'(elem);
        nf_cnt   = ADDR_W'(nf_m1) + ADDR_W'(1);
        seq      = elem_x * nf_cnt + ADDR_W'(fld);
        fld_step = ADDR_W'(fld) << ((mode == VM_INDEX) ? sew : eew);
        unique case (mode)
            VM_STRIDE: addr = base + stride * elem_x + fld_step;
            VM_INDEX:  addr = base + idx_off + fld_step;
            default:   addr = base + (seq << eew);
        endcase
        size = (mode == VM_INDEX) ? sew : eew;
    end
endmodule

// File: rtl/vmem_addr_seq.sv
// Vector memory address sequencer top. It captures one instruction's
// configuration on an accepted start and issues a request beat for every
// field of every active element. Assumes the instruction is legal and that
// mask_bit and idx_raw answer elem_sel within the same cycle.
module vmem_addr_seq
    import vmem_seq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int VL_W   = 8,
    parameter int IDX_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic [2:0]        nf_m1_in,
    input  logic [1:0]        eew_in,
    input  logic [1:0]        sew_in,
    input  logic [1:0]        emul_lg_in,
    input  logic [1:0]        lmul_lg_in,
    input  logic [4:0]        vd_in,
    input  logic              mask_en_in,
    input  logic [VL_W-1:0]   vl_in,
    input  logic [VL_W-1:0]   vstart_in,
    output logic [VL_W-1:0]   elem_sel,
    input  logic              mask_bit,
    input  logic [IDX_W-1:0]  idx_raw,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_size,
    output logic [4:0]        req_reg,
    output logic [VL_W-1:0]   req_elem,
    output logic [VL_W-1:0]   vstart_out,
    output logic              done
);
    vcfg_t             cfg_q;
    logic [ADDR_W-1:0] base_q, stride_q, idx_off;
    logic [VL_W-1:0]   vl_q, elem;
    logic [NF_W-1:0]   fld;
    logic              cap;
    logic [1:0]        grp;
    logic [REG_W-1:0]  reg_step;

    // Capture the instruction configuration when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            base_q   <= '0;
            stride_q <= '0;
            vl_q     <= '0;
        end else if (cap) begin
            cfg_q.mode    <= vmode_e'(mode_in);
            cfg_q.nf_m1   <= nf_m1_in;
            cfg_q.eew     <= eew_in;
            cfg_q.sew     <= sew_in;
            cfg_q.emul_lg <= emul_lg_in;
            cfg_q.lmul_lg <= lmul_lg_in;
            cfg_q.vd      <= vd_in;
            cfg_q.mask_en <= mask_en_in;
            base_q        <= base_in;
            stride_q      <= stride_in;
            vl_q          <= vl_in;
        end
    end

    vmem_seq_ctrl #(.VL_W(VL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vstart_in  (vstart_in),
        .vl_q       (vl_q),
        .nf_m1_q    (cfg_q.nf_m1),
        .mask_en_q  (cfg_q.mask_en),
        .mask_bit   (mask_bit),
        .req_ready  (req_ready),
        .cap        (cap),
        .elem       (elem),
        .fld        (fld),
        .req_valid  (req_valid),
        .done       (done),
        .vstart_out (vstart_out)
    );

    vmem_idx_ext #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_idx (
        .raw  (idx_raw),
        .wsel (cfg_q.eew),
        .off  (idx_off)
    );

    vmem_addr_gen #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_agen (
        .mode    (cfg_q.mode),
        .base    (base_q),
        .stride  (stride_q),
        .elem    (elem),
        .fld     (fld),
        .nf_m1   (cfg_q.nf_m1),
        .eew     (cfg_q.eew),
        .sew     (cfg_q.sew),
        .idx_off (idx_off),
        .addr    (req_addr),
        .size    (req_size)
    );

    // Target register: field number scaled by the mode's group size
    always_comb begin
        grp      = (cfg_q.mode == VM_INDEX) ? cfg_q.lmul_lg : cfg_q.emul_lg;
        reg_step = REG_W'(fld) << grp;
        req_reg  = cfg_q.vd + reg_step;
        req_elem = elem;
        elem_sel = elem;
    end
endmodule

// File: rtl/vmem_addr_seq_chk.sv
// Port-level checker for the vector memory address sequencer.
// Assumes lookups answer elem_sel combinationally.
module vmem_addr_seq_chk #(
    parameter int ADDR_W = 64,
    parameter int VL_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [4:0]        req_reg,
    input logic [VL_W-1:0]   req_elem,
    input logic [VL_W-1:0]   vstart_out,
    input logic              done
);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
        $stable(req_size) && $stable(req_reg) && $stable(req_elem));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid && vstart_out == '0);

    // R9
    vstart_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> vstart_out == req_elem);

    // R2
    elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid || req_elem >= $past(req_elem));
endmodule

bind vmem_addr_seq vmem_addr_seq_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_reg    (req_reg),
    .req_elem   (req_elem),
    .vstart_out (vstart_out),
    .done       (done)
);

// File: tb/vmem_addr_seq_tb.sv
// Scoreboard bench: run_case pushes the expected beats, monitor pops them.
module vmem_addr_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode_in = '0;
    logic [63:0] base_in = '0, stride_in = '0;
    logic [2:0]  nf_m1_in = '0;
    logic [1:0]  eew_in = '0, sew_in = '0, emul_lg_in = '0, lmul_lg_in = '0;
    logic [4:0]  vd_in = '0;
    logic        mask_en_in = 1'b0;
    logic [7:0]  vl_in = '0, vstart_in = '0;
    logic [7:0]  elem_sel;
    logic        mask_bit;
    logic [63:0] idx_raw;
    logic        req_valid, req_ready = 1'b1;
    logic [63:0] req_addr;
    logic [1:0]  req_size;
    logic [4:0]  req_reg;
    logic [7:0]  req_elem, vstart_out;
    logic        done;

    logic [63:0] mask_pat = '1;
    logic [63:0] idx_mem [64];
    assign mask_bit = mask_pat[elem_sel[5:0]];
    assign idx_raw  = idx_mem[elem_sel[5:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    vmem_addr_seq u_dut (.*);

    typedef struct {
        logic [63:0] addr;
        logic [1:0]  size;
        logic [4:0]  rg;
        logic [7:0]  el;
    } beat_t;
    beat_t exp_q[$];

    int    n_chk = 0, n_fail = 0, done_cnt = 0;
    string cur_tag = "R1";
    logic  bp = 1'b0;
    logic [7:0] lfsr = 8'h5B;
    logic  prev_stall = 1'b0;
    beat_t prev_b;
    logic  ended = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: hold check, ready pattern, and scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk("R8 valid held", 64'(req_valid), 64'd1);
                chk("R8 addr held", req_addr, prev_b.addr);
                chk("R8 elem held", 64'(req_elem), 64'(prev_b.el));
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            req_ready = bp ? lfsr[0] : 1'b1;
            if (req_valid && req_ready) begin
                if (exp_q.size() == 0) begin
                    chk({cur_tag, " R2 unexpected beat"}, 64'(req_elem), 64'hFFFF);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk({cur_tag, " addr"}, req_addr, e.addr);
                    chk({cur_tag, " size"}, 64'(req_size), 64'(e.size));
                    chk("R7 reg", 64'(req_reg), 64'(e.rg));
                    chk("R2 elem", 64'(req_elem), 64'(e.el));
                    chk("R9 vstart", 64'(vstart_out), 64'(e.el));
                end
            end
            if (done) begin
                done_cnt++;
                chk("R10 done without valid", 64'(req_valid), 64'd0);
            end
            prev_stall = req_valid && !req_ready;
            prev_b.addr = req_addr;
            prev_b.el   = req_elem;
        end
    end

    function automatic logic [63:0] zext(input logic [63:0] r, input int w);
        case (w)
            0: return r & 64'hFF;
            1: return r & 64'hFFFF;
            2: return r & 64'hFFFF_FFFF;
            default: return r;
        endcase
    endfunction

    task automatic run_case(input string tag, input int mode, input logic [63:0] base,
                            input logic [63:0] stride, input int nfm1, input int eew,
                            input int sew, input int emul, input int lmul, input int vd,
                            input logic msk, input int vl, input int vs,
                            input logic use_bp, input logic poke);
        int d0;
        for (int i = vs; i < vl; i++) begin
            if (msk && !mask_pat[i]) continue;
            for (int f = 0; f <= nfm1; f++) begin
                beat_t b;
                logic [63:0] ix;
                ix = 64'(i);
                if (mode == 1)
                    b.addr = base + stride * ix + (64'(f) << eew);
                else if (mode == 2)
                    b.addr = base + zext(idx_mem[i], eew) + (64'(f) << sew);
                else
                    b.addr = base + ((ix * 64'(nfm1 + 1) + 64'(f)) << eew);
                b.size = 2'((mode == 2) ? sew : eew);
                b.rg   = 5'((vd + (f << ((mode == 2) ? lmul : emul))) % 32);
                b.el   = 8'(i);
                exp_q.push_back(b);
            end
        end
        cur_tag = tag;
        bp = use_bp;
        d0 = done_cnt;
        @(negedge clk);
        mode_in = 2'(mode); base_in = base; stride_in = stride; nf_m1_in = 3'(nfm1);
        eew_in = 2'(eew); sew_in = 2'(sew); emul_lg_in = 2'(emul); lmul_lg_in = 2'(lmul);
        vd_in = 5'(vd); mask_en_in = msk; vl_in = 8'(vl); vstart_in = 8'(vs);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            mode_in = 2'd2; base_in = 64'hBAD0_0000; vl_in = 8'd40; vstart_in = 8'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        chk({tag, " R2 all beats issued"}, 64'(exp_q.size()), 64'd0);
        chk("R9 vstart back to 0", 64'(vstart_out), 64'd0);
        chk("R10 idle after done", 64'(req_valid), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        for (int i = 0; i < 64; i++)
            idx_mem[i] = 64'hC3A5_0000_0000_0000 ^ (64'(i) * 64'h0001_0203_0407_0913);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", 64'(req_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 vstart", 64'(vstart_out), 64'd0);
        // contiguous, single field, 4-byte elements
        run_case("R4", 0, 64'h1000, 0, 0, 2, 0, 0, 0, 4, 1'b0, 5, 0, 1'b0, 1'b0);
        // contiguous segments, resume at 2, mask and backpressure
        mask_pat = 64'hFFFF_FFFF_FFFF_FFB6;
        run_case("R3", 0, 64'h2000, 0, 2, 1, 0, 1, 0, 2, 1'b1, 9, 2, 1'b1, 1'b0);
        // mask disabled: pattern must not matter
        run_case("R3", 0, 64'h2400, 0, 1, 0, 0, 0, 0, 0, 1'b0, 6, 0, 1'b1, 1'b0);
        // reserved mode code behaves as contiguous
        run_case("R4", 3, 64'h2800, 0, 1, 3, 0, 2, 0, 1, 1'b0, 3, 0, 1'b0, 1'b0);
        mask_pat = '1;
        // strided, negative stride, two fields
        run_case("R5", 1, 64'h8000, -64'sd24, 1, 3, 0, 1, 0, 6, 1'b0, 4, 0, 1'b1, 1'b0);
        // register wrap past 31
        run_case("R7", 1, 64'h100, 64'd64, 3, 2, 0, 1, 0, 30, 1'b0, 3, 0, 1'b0, 1'b0);
        // indexed at each index width; lmul chosen over emul
        run_case("R6", 2, 64'h4000, 0, 1, 0, 2, 0, 2, 8, 1'b0, 5, 0, 1'b1, 1'b0);
        run_case("R6", 2, 64'h4000, 0, 0, 1, 3, 3, 1, 3, 1'b0, 4, 1, 1'b0, 1'b0);
        run_case("R6", 2, 64'h0, 0, 2, 2, 0, 0, 0, 12, 1'b0, 3, 0, 1'b1, 1'b0);
        run_case("R6", 2, 64'h10, 0, 0, 3, 1, 0, 0, 16, 1'b0, 3, 0, 1'b0, 1'b0);
        // resume point at or past the length: no beats
        run_case("R10", 0, 64'h500, 0, 0, 0, 0, 0, 0, 0, 1'b0, 4, 4, 1'b0, 1'b0);
        run_case("R10", 0, 64'h500, 0, 0, 0, 0, 0, 0, 0, 1'b0, 2, 7, 1'b0, 1'b0);
        // every element masked off
        mask_pat = '0;
        run_case("R3", 1, 64'h600, 64'd8, 1, 1, 0, 0, 0, 0, 1'b1, 5, 0, 1'b0, 1'b0);
        mask_pat = '1;
        // start raised mid-instruction is ignored
        run_case("R11", 1, 64'h9000, 64'd100, 2, 1, 0, 1, 0, 4, 1'b0, 6, 0, 1'b1, 1'b1);
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired (tag %s) actual=hung expected=done", cur_tag);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule